// File: doc/BRIEF.md
# I/O Controller Interrupt Aggregator

The block collects interrupt requests from the peripherals of a memory-mapped I/O chip and turns them into a cause byte and one level-high CPU interrupt line. The cause byte has one bit per source group: the primary peripheral's interrupt unit, the secondary peripheral, the serial controller, Ethernet, DMA and NMI. Some groups are gated before they set their cause bit. A primary-peripheral request goes to the primary or the secondary group, depending on the primary unit's flag summary and on two secondary enable registers. DMA requests count only while the matching DMA interrupt register is nonzero.

Software reaches the block through a byte register bus with 18-bit offsets. The bus writes on `we_i` and returns read data combinationally for `addr_i`. Bit 7 of the control register is the acknowledge bit. Writing the control register with bit 7 set acknowledges. Reading the control register while its bit 7 is set also acknowledges. An explicit acknowledge port clears selected causes. Bit 6 of the control register is a force bit: it lets every request through its gate.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads 0x00, the cause byte is 0x00 and `cpu_irq_o` is low.
- R2: These offsets are plain read/write byte registers: control 0x2A000 (a write with bit 7 clear stores all 8 bits), DMA interrupt 0 at 0x2A008, DMA interrupt 1 at 0x2A00A, bus-error 0 at 0x2A009, bus-error 1 at 0x2A00B, secondary slot enable at 0x26012, secondary general enable at 0x26013, secondary slot status at 0x26002 and secondary general status at 0x26003. A read of any unmapped offset returns 0x00.
- R3: The cause byte reads at offset 0x2A004 and ignores writes. Its bits are: bit 0 primary, bit 1 secondary, bit 2 serial, bit 3 Ethernet, bit 4 DMA, bit 5 NMI. Bits 7:6 read 0. `cpu_irq_o` is high in every cycle in which any cause bit is set. A cause bit stays set until it is cleared.
- R4: A pulse on `pri_req_i` sets cause bit 0 one cycle later if `pri_flags_i` is nonzero. Otherwise it sets cause bit 1 if either secondary enable register is nonzero. Otherwise, with force clear, it sets nothing.
- R5: With force clear, `dma_ch_req_i` sets cause bit 4 only while DMA interrupt register 0 is nonzero, and `dma_snd_req_i` sets it only while DMA interrupt register 1 is nonzero.
- R6: Any write to the sound output DMA control offset 0x14018 sets bit 1 of DMA interrupt register 1 and sets cause bit 4.
- R7: `ser_req_i`, `eth_req_i` and `nmi_req_i` set cause bits 2, 3 and 5 with no gating.
- R8: While control bit 6 (force) is set, the DMA gates of R5 are open. A primary request with a zero flag summary then sets cause bit 1 even when both enables are zero.
- R9: A control write with bit 7 set stores only the written bits 7:6 and clears all cause bits.
- R10: A control read while control bit 7 is set returns the current control value and clears all cause bits. A control read with bit 7 clear changes nothing.
- R11: A pulse on `ack_i` clears the cause bits selected by `ack_bits_i[5:0]`. It does so only when control bit 7 is set and `ack_bits_i` shares at least one set bit with the control register. Otherwise it has no effect.
- R12: When a request and a clear hit the same cause bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 18 | Register byte offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (side effects only) |
| rdata_o | output | 8 | Read data for addr_i |
| pri_req_i | input | 1 | Primary peripheral request pulse |
| pri_flags_i | input | 8 | Primary peripheral flag summary |
| ser_req_i | input | 1 | Serial controller request |
| eth_req_i | input | 1 | Ethernet request |
| dma_ch_req_i | input | 1 | Floppy/Ethernet/serial DMA channel request |
| dma_snd_req_i | input | 1 | Sound DMA request |
| nmi_req_i | input | 1 | NMI request |
| ack_i | input | 1 | Explicit acknowledge strobe |
| ack_bits_i | input | 8 | Device bits presented with the acknowledge |
| cpu_irq_o | output | 1 | CPU interrupt, level high |

## Verification
A cause bit that is wrongly set or stuck shows up on `cpu_irq_o` and in the cause byte one cycle after the request or acknowledge that should have changed it. A wrong gate decision for DMA or secondary requests shows up in the same way, and the bench reads the cause byte right after each stimulus. A mismasked control write or a missed acknowledge side effect appears on the next control or cause read. The bench therefore samples every effect in the first cycle after its cause.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W    = 8;
  localparam int OFS_W     = 18;
  localparam int NUM_CAUSE = 6;
  localparam int NUM_REG   = 8;

  localparam int C_PRI = 0;
  localparam int C_SEC = 1;
  localparam int C_SER = 2;
  localparam int C_ETH = 3;
  localparam int C_DMA = 4;
  localparam int C_NMI = 5;

  localparam int IDX_DMA0    = 0;
  localparam int IDX_BERR0   = 1;
  localparam int IDX_DMA1    = 2;
  localparam int IDX_BERR1   = 3;
  localparam int IDX_SLOT_EN = 4;
  localparam int IDX_GEN_EN  = 5;
  localparam int IDX_SLOT_ST = 6;
  localparam int IDX_GEN_ST  = 7;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 18'h2A000;
  localparam logic [OFS_W-1:0] OFS_CAUSE = 18'h2A004;
  localparam logic [OFS_W-1:0] OFS_SND   = 18'h14018;

  localparam logic [DATA_W-1:0] ACK_KEEP = 8'hC0;
  localparam logic [DATA_W-1:0] SND_SET  = 8'h02;

  function automatic logic [OFS_W-1:0] reg_ofs(input int idx);
    case (idx)
      IDX_DMA0:    return 18'h2A008;
      IDX_BERR0:   return 18'h2A009;
      IDX_DMA1:    return 18'h2A00A;
      IDX_BERR1:   return 18'h2A00B;
      IDX_SLOT_EN: return 18'h26012;
      IDX_GEN_EN:  return 18'h26013;
      IDX_SLOT_ST: return 18'h26002;
      default:     return 18'h26003;
    endcase
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    we_i,
  output logic [DATA_W-1:0]       ctrl_o,
  output logic [DATA_W-1:0]       regs_o [NUM_REG],
  output logic                    wr_ack_o,
  output logic                    snd_wr_o
);
  logic ctrl_hit;
  logic [DATA_W-1:0] ctrl_q;

  assign ctrl_hit = (addr_i == ADDR_W'(OFS_CTRL));
  assign snd_wr_o = we_i && (addr_i == ADDR_W'(OFS_SND));
  assign wr_ack_o = we_i && ctrl_hit && wdata_i[7];
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && ctrl_hit) ctrl_q <= wdata_i[7] ? (wdata_i & ACK_KEEP) : wdata_i;
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic hit;
    logic [DATA_W-1:0] q;
    assign hit = (addr_i == ADDR_W'(reg_ofs(g)));
    assign regs_o[g] = q;
    if (g == IDX_DMA1) begin : g_snd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && hit) q <= wdata_i;
        else if (snd_wr_o) q <= q | SND_SET;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && hit) q <= wdata_i;
      end
    end
  end

  AST_ACK_WR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |=> ctrl_q == ($past(wdata_i) & ACK_KEEP)); // R9
  AST_SND_DMA1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_wr_o |=> regs_o[IDX_DMA1][1]); // R6
endmodule

// File: rtl/irq_ack.sv
module irq_ack
  import irq_agg_pkg::*;
(
  input  logic [DATA_W-1:0]    ctrl_i,
  input  logic                 rd_ctrl_i,
  input  logic                 wr_ack_i,
  input  logic                 ext_ack_i,
  input  logic [DATA_W-1:0]    ext_bits_i,
  output logic [NUM_CAUSE-1:0] clr_o
);
  logic rd_ack, ext_ok;

  assign rd_ack = rd_ctrl_i && ctrl_i[7];
  assign ext_ok = ext_ack_i && ctrl_i[7] && |(ext_bits_i & ctrl_i);

  always_comb begin
    clr_o = '0;
    if (rd_ack || wr_ack_i) clr_o = '1;
    else if (ext_ok)        clr_o = ext_bits_i[NUM_CAUSE-1:0];
  end
endmodule

// File: rtl/irq_cause.sv
module irq_cause
  import irq_agg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    ctrl_i,
  input  logic                 en_any_i,
  input  logic                 dma0_nz_i,
  input  logic                 dma1_nz_i,
  input  logic                 pri_req_i,
  input  logic [DATA_W-1:0]    pri_flags_i,
  input  logic                 ser_req_i,
  input  logic                 eth_req_i,
  input  logic                 dma_ch_req_i,
  input  logic                 dma_snd_req_i,
  input  logic                 snd_wr_i,
  input  logic                 nmi_req_i,
  input  logic [NUM_CAUSE-1:0] clr_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  logic force_en, flags_nz;
  logic [NUM_CAUSE-1:0] set, cause_q;

  assign force_en = ctrl_i[6];
  assign flags_nz = |pri_flags_i;

  always_comb begin
    set        = '0;
    set[C_PRI] = pri_req_i && flags_nz;
    set[C_SEC] = pri_req_i && !flags_nz && (en_any_i || force_en);
    set[C_SER] = ser_req_i;
    set[C_ETH] = eth_req_i;
    set[C_DMA] = (dma_ch_req_i && (dma0_nz_i || force_en))
               || (dma_snd_req_i && (dma1_nz_i || force_en))
               || snd_wr_i;
    set[C_NMI] = nmi_req_i;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (cause_q & ~clr_i) | set;
  end

  assign cause_o = cause_q;

  AST_NMI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_i |=> cause_q[C_NMI]); // R7
  AST_ACK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&clr_i) && !pri_req_i && !ser_req_i && !eth_req_i && !dma_ch_req_i
     && !dma_snd_req_i && !snd_wr_i && !nmi_req_i) |=> cause_q == '0); // R9
  AST_DMA_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ch_req_i && !dma_snd_req_i && !snd_wr_i && !dma0_nz_i && !ctrl_i[6]
     && !cause_q[C_DMA]) |=> !cause_q[C_DMA]); // R5
  AST_SEC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_req_i && !flags_nz && !en_any_i && !ctrl_i[6] && !cause_q[C_SEC])
    |=> !cause_q[C_SEC]); // R4
  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R3
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    ctrl_i,
  input  logic [DATA_W-1:0]    regs_i [NUM_REG],
  input  logic [NUM_CAUSE-1:0] cause_i,
  output logic [DATA_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL))  rdata_o = ctrl_i;
    if (addr_i == ADDR_W'(OFS_CAUSE)) rdata_o = DATA_W'(cause_i);
    for (int i = 0; i < NUM_REG; i++)
      if (addr_i == ADDR_W'(reg_ofs(i))) rdata_o = regs_i[i];
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [7:0]        rdata_o,
  input  logic              pri_req_i,
  input  logic [7:0]        pri_flags_i,
  input  logic              ser_req_i,
  input  logic              eth_req_i,
  input  logic              dma_ch_req_i,
  input  logic              dma_snd_req_i,
  input  logic              nmi_req_i,
  input  logic              ack_i,
  input  logic [7:0]        ack_bits_i,
  output logic              cpu_irq_o
);
  logic [DATA_W-1:0]    ctrl;
  logic [DATA_W-1:0]    regs [NUM_REG];
  logic                 wr_ack, snd_wr, rd_ctrl;
  logic [NUM_CAUSE-1:0] clr, cause;

  assign rd_ctrl = re_i && (addr_i == ADDR_W'(OFS_CTRL));

  irq_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .ctrl_o(ctrl), .regs_o(regs), .wr_ack_o(wr_ack), .snd_wr_o(snd_wr)
  );

  irq_ack u_ack (
    .ctrl_i(ctrl), .rd_ctrl_i(rd_ctrl), .wr_ack_i(wr_ack),
    .ext_ack_i(ack_i), .ext_bits_i(ack_bits_i), .clr_o(clr)
  );

  irq_cause u_cause (
    .clk_i, .rst_ni, .ctrl_i(ctrl),
    .en_any_i(|(regs[IDX_SLOT_EN] | regs[IDX_GEN_EN])),
    .dma0_nz_i(|regs[IDX_DMA0]), .dma1_nz_i(|regs[IDX_DMA1]),
    .pri_req_i, .pri_flags_i, .ser_req_i, .eth_req_i,
    .dma_ch_req_i, .dma_snd_req_i, .snd_wr_i(snd_wr), .nmi_req_i,
    .clr_i(clr), .cause_o(cause)
  );

  irq_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .addr_i, .ctrl_i(ctrl), .regs_i(regs), .cause_i(cause), .rdata_o
  );

  assign cpu_irq_o = |cause;

  AST_RD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && ctrl[7] && !pri_req_i && !ser_req_i && !eth_req_i && !dma_ch_req_i
     && !dma_snd_req_i && !nmi_req_i && !we_i) |=> !cpu_irq_o); // R10
  AST_EXT_NOACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ctrl[7] && !rd_ctrl && !we_i) |=> ((cause & $past(cause)) == $past(cause))); // R11
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  logic clk = 0, rst_n = 0;
  logic [17:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pri_flags = '0, ack_bits = '0;
  logic we = 0, re = 0, pri = 0, ser = 0, eth = 0, dch = 0, dsnd = 0, nmi = 0, ack = 0;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_aggregator u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .pri_req_i(pri), .pri_flags_i(pri_flags), .ser_req_i(ser),
    .eth_req_i(eth), .dma_ch_req_i(dch), .dma_snd_req_i(dsnd), .nmi_req_i(nmi),
    .ack_i(ack), .ack_bits_i(ack_bits), .cpu_irq_o(irq)
  );

  localparam logic [17:0] A_CTRL = 18'h2A000, A_CAUSE = 18'h2A004, A_DMA0 = 18'h2A008,
                          A_DMA1 = 18'h2A00A, A_GEN = 18'h26013, A_SND = 18'h14018;

  // {addr, write data, expected readback}
  localparam int NV = 11;
  localparam logic [33:0] VEC [NV] = '{
    {18'h2A000, 8'h3F, 8'h3F}, {18'h2A008, 8'h11, 8'h11}, {18'h2A009, 8'h22, 8'h22},
    {18'h2A00A, 8'h33, 8'h33}, {18'h2A00B, 8'h44, 8'h44}, {18'h26012, 8'h55, 8'h55},
    {18'h26013, 8'h66, 8'h66}, {18'h26002, 8'h77, 8'h77}, {18'h26003, 8'h88, 8'h88},
    {18'h2A004, 8'hFF, 8'h00}, {18'h20000, 8'h5A, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1; cyc(); we = 0;
  endtask

  task automatic rd(input logic [17:0] a, input logic [7:0] exp, input string tag);
    addr = a; re = 1; #1 chk(tag, rdata, exp); cyc(); re = 0;
  endtask

  // m: 0 pri, 1 ser, 2 eth, 3 dma ch, 4 dma snd, 5 nmi
  task automatic req(input logic [5:0] m, input logic [7:0] f);
    pri = m[0]; ser = m[1]; eth = m[2]; dch = m[3]; dsnd = m[4]; nmi = m[5]; pri_flags = f;
    cyc();
    {pri, ser, eth, dch, dsnd, nmi} = '0; pri_flags = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) cyc(); rst_n = 1; cyc();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][33:16], VEC[i][15:8]);
      rd(VEC[i][33:16], VEC[i][7:0], "R2/R3 register map");
    end

    do_reset();
    chk("R1 irq low", {7'd0, irq}, 8'h00);
    rd(A_CAUSE, 8'h00, "R1 cause");
    rd(A_CTRL, 8'h00, "R1 ctrl");
    rd(A_DMA1, 8'h00, "R1 dma1");

    req(6'b000001, 8'h04);
    rd(A_CAUSE, 8'h01, "R4 primary");
    chk("R3 irq high", {7'd0, irq}, 8'h01);

    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, 8'hC0, "R9 ctrl masked");
    rd(A_CAUSE, 8'h00, "R9 cleared");
    chk("R3 irq low", {7'd0, irq}, 8'h00);
    wr(A_CTRL, 8'h00);

    req(6'b000001, 8'h00);
    rd(A_CAUSE, 8'h00, "R4 gated off");
    wr(A_GEN, 8'h01);
    req(6'b000001, 8'h00);
    rd(A_CAUSE, 8'h02, "R4 secondary");

    req(6'b001000, 8'h00);
    rd(A_CAUSE, 8'h02, "R5 dma0 zero");
    wr(A_DMA0, 8'h01);
    req(6'b001000, 8'h00);
    rd(A_CAUSE, 8'h12, "R5 dma0 set");

    wr(A_CTRL, 8'h80);
    rd(A_CAUSE, 8'h00, "R9 ack write");
    req(6'b010000, 8'h00);
    rd(A_CAUSE, 8'h00, "R5 dma1 zero");
    wr(A_SND, 8'h00);
    rd(A_DMA1, 8'h02, "R6 dma1 bit1");
    rd(A_CAUSE, 8'h10, "R6 cause");

    req(6'b100110, 8'h00);
    rd(A_CAUSE, 8'h3C, "R7 ungated");

    rd(A_CTRL, 8'h80, "R10 read value");
    rd(A_CAUSE, 8'h00, "R10 read ack");

    req(6'b100010, 8'h00);
    addr = A_CAUSE; ack = 1; ack_bits = 8'h04; cyc(); ack = 0;
    rd(A_CAUSE, 8'h24, "R11 no overlap");
    ack = 1; ack_bits = 8'h84; cyc(); ack = 0;
    rd(A_CAUSE, 8'h20, "R11 selective");

    wr(A_CTRL, 8'hC0);
    wr(A_GEN, 8'h00);
    wr(A_DMA0, 8'h00);
    wr(18'h2A00A, 8'h00);
    req(6'b011001, 8'h00);
    rd(A_CAUSE, 8'h12, "R8 forced");

    wr(A_CTRL, 8'h00);
    rd(A_CTRL, 8'h00, "R10 ctrl clear");
    rd(A_CAUSE, 8'h12, "R10 no ack");

    addr = A_CTRL; wdata = 8'h80; we = 1; nmi = 1; cyc(); we = 0; nmi = 0;
    rd(A_CAUSE, 8'h20, "R12 set wins");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule